// File: doc/BRIEF.md
# Paced parallel input capture controller

This block moves samples from a parallel input port into an input FIFO. Software first picks how samples are timed. An internal pacer can take one sample every fixed number of clock cycles. An external request line can act as a data strobe, with its active edge set by polarity. A request/acknowledge handshake lets the external device control the flow itself, so that it cannot overrun the block.

Each sample is 32, 16 or 8 bits wide. Narrow samples are packed into full FIFO words, with the earliest sample in the least significant lane. Capture can be held off until a start trigger is asserted. The request, acknowledge and trigger pins each have a programmable polarity. The FIFO storage itself sits on the drain side. The block gives it a write strobe, a one-cycle clear pulse and a full input. When a word completes while the FIFO is full, the word is dropped and a sticky overrun flag is set.

Configuration is written through a small register port. Address 0 is the control register:
- [0] enables capture.
- [1] is a clear strobe.
- [3:2] selects the clock source: 0 pacer, 1 strobe, 2 handshake.
- [5:4] selects the width: 0 = 32 bits, 1 = 16, 2 = 8.
- [6] is wait-for-trigger.
- [7] clears the overrun flag when written as one.

Address 1 holds the polarity bits:
- [0] inverts the request pin.
- [1] inverts the acknowledge pin.
- [2] inverts the trigger pin.

Address 2 holds the pacer divisor DIV.

Top module: `pinput_capture`

## Requirements
- R1: After reset, no FIFO write is issued, the acknowledge pin is low, the overrun flag is 0 and no clear pulse is issued.
- R2: In pacer mode (control [3:2]=0), one sample is taken every DIV+1 clock cycles while capture runs.
- R3: Width code 1 packs two 16-bit samples per word, and width code 2 packs four 8-bit samples per word. The earliest sample goes in bits [w-1:0], and each later sample goes in the next higher lane.
- R4: In strobe mode (control [3:2]=1), each rising edge of the logical request captures one sample. The logical request is the pin XOR polarity [0]. For 32-bit width, the FIFO write is issued on the third clock edge after the pin changes.
- R5: In handshake mode (control [3:2]=2), the logical request is sampled and the logical acknowledge rises on the third edge after the request pin rises. The acknowledge stays asserted while the request is held. It falls on the third edge after the request pin drops. Each request assertion captures exactly one sample. The acknowledge pin equals the logical acknowledge XOR polarity [1].
- R6: When control [6] is set, no sample is taken until the logical trigger (pin XOR polarity [2]) is asserted. In pacer mode, the first word is then written DIV+4 edges after the trigger pin changes.
- R7: While control [0] is 0, no sample is taken and no FIFO write is issued.
- R8: Writing control [1] as one issues a single-cycle clear pulse on the edge after the write. It also discards any partially packed word.
- R9: A word that completes while the FIFO is full is not written, and the overrun flag is set.
- R10: The overrun flag stays set until control [7] is written as one. A control write with [7] at zero leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | CFG_W | Register write data |
| din | input | DATA_W | Parallel input port |
| req_pin | input | 1 | External request / strobe |
| trig_pin | input | 1 | External start trigger |
| ack_pin | output | 1 | Handshake acknowledge |
| fifo_full | input | 1 | FIFO full indication from the drain side |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Each pin event reaches the outputs after a fixed number of edges:
- A strobe or handshake request takes two synchronizer edges plus one register edge before a FIFO write or acknowledge appears.
- The acknowledge falls after the same three edges once the request is released.
- A trigger start adds DIV+1 pacer cycles on top of its three edges.
- The clear pulse follows one edge after its register write.

The bench stamps every FIFO write with the clock count at which it was seen, one nanosecond after the edge, and compares that stamp with the stimulus cycle plus the latency above. In pacer mode, the data port counts up once per cycle, so each expected word follows from the counter value and DIV. In strobe and handshake runs, the captured samples are queued and packed by a bench function.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      CLK_PACER  = 2'd0,
      CLK_STROBE = 2'd1,
      CLK_HSHAKE = 2'd2
   } clk_mode_e;

   localparam logic [1:0] WID_FULL    = 2'd0;
   localparam logic [1:0] WID_HALF    = 2'd1;
   localparam logic [1:0] WID_QUARTER = 2'd2;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_POL  = 2'd1;
   localparam logic [1:0] ADDR_DIV  = 2'd2;

   localparam int CTRL_EN   = 0;
   localparam int CTRL_CLR  = 1;
   localparam int CTRL_MODE = 2;
   localparam int CTRL_WID  = 4;
   localparam int CTRL_WAIT = 6;
   localparam int CTRL_OVRC = 7;

   localparam int POL_REQ  = 0;
   localparam int POL_ACK  = 1;
   localparam int POL_TRIG = 2;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "pic_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/pic_pacer.sv
module pic_pacer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] div,
   output logic         tick
);
   generate
      if (W < 1) begin : g_bad_w
         $fatal(1, "pic_pacer: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/pic_packer.sv
module pic_packer #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              samp,
   input  logic [1:0]        wid,
   input  logic              full,
   input  logic [DATA_W-1:0] din,
   output logic              push,
   output logic              drop,
   output logic [DATA_W-1:0] wdata
);
   import pic_pkg::*;

   localparam int HALF = DATA_W / 2;
   localparam int QTR  = DATA_W / 4;

   generate
      if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_w
         $fatal(1, "pic_packer: DATA_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] acc, nxt;
   logic [1:0]        idx;
   logic              last;

   always_comb begin
      case (wid)
         WID_HALF: begin
            nxt  = {din[HALF-1:0], acc[DATA_W-1:HALF]};
            last = (idx == 2'd1);
         end
         WID_QUARTER: begin
            nxt  = {din[QTR-1:0], acc[DATA_W-1:QTR]};
            last = (idx == 2'd3);
         end
         default: begin
            nxt  = din;
            last = 1'b1;
         end
      endcase
   end

   assign drop = samp && last && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         idx   <= '0;
         push  <= 1'b0;
         wdata <= '0;
      end else begin
         push <= samp && last && !full;
         if (samp && last) wdata <= nxt;
         if (samp) acc <= nxt;
         if (flush)          idx <= '0;
         else if (samp)      idx <= last ? 2'd0 : idx + 2'd1;
      end
   end
endmodule

// File: rtl/pinput_capture.sv
module pinput_capture
   import pic_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int PACER_W     = 16,
   parameter int CFG_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [DATA_W-1:0] din,
   input  logic              req_pin,
   input  logic              trig_pin,
   output logic              ack_pin,
   input  logic              fifo_full,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              fifo_clr,
   output logic              overrun
);
   generate
      if (CFG_W < 8 || PACER_W > CFG_W) begin : g_bad_cfg
         $fatal(1, "pinput_capture: CFG_W must hold the control byte and the divisor");
      end
   endgenerate

   logic                en_q, wait_q, clr_q, ovr_q;
   logic                trig_seen, ack_q, req_prev;
   clk_mode_e           mode_q;
   logic [1:0]          wid_q;
   logic [2:0]          pol_q;
   logic [PACER_W-1:0]  div_q;
   logic                ctrl_wr, req_lvl, trig_lvl, req_rise;
   logic                running, tick, samp, drop;

   assign ctrl_wr = cfg_we && (cfg_addr == ADDR_CTRL);

   // register port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         wait_q <= 1'b0;
         clr_q  <= 1'b0;
         ovr_q  <= 1'b0;
         mode_q <= CLK_PACER;
         wid_q  <= WID_FULL;
         pol_q  <= '0;
         div_q  <= '0;
      end else begin
         clr_q <= ctrl_wr && cfg_wdata[CTRL_CLR];
         if (ctrl_wr) begin
            en_q   <= cfg_wdata[CTRL_EN];
            mode_q <= clk_mode_e'(cfg_wdata[CTRL_MODE +: 2]);
            wid_q  <= cfg_wdata[CTRL_WID +: 2];
            wait_q <= cfg_wdata[CTRL_WAIT];
         end
         if (cfg_we && cfg_addr == ADDR_POL) pol_q <= cfg_wdata[2:0];
         if (cfg_we && cfg_addr == ADDR_DIV) div_q <= cfg_wdata[PACER_W-1:0];
         ovr_q <= (ovr_q && !(ctrl_wr && cfg_wdata[CTRL_OVRC])) || drop;
      end
   end

   // pin conditioning
   pic_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk (clk), .rst_n (rst_n),
      .din (req_pin ^ pol_q[POL_REQ]),
      .lvl (req_lvl)
   );

   pic_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk (clk), .rst_n (rst_n),
      .din (trig_pin ^ pol_q[POL_TRIG]),
      .lvl (trig_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev  <= 1'b0;
         trig_seen <= 1'b0;
      end else begin
         req_prev <= req_lvl;
         if (!en_q || ctrl_wr) trig_seen <= 1'b0;
         else if (trig_lvl)    trig_seen <= 1'b1;
      end
   end

   assign req_rise = req_lvl && !req_prev;
   assign running  = en_q && (!wait_q || trig_seen);

   pic_pacer #(.W(PACER_W)) u_pacer (
      .clk (clk), .rst_n (rst_n),
      .run (running && mode_q == CLK_PACER),
      .div (div_q),
      .tick(tick)
   );

   // sample event per clock source
   always_comb begin
      case (mode_q)
         CLK_PACER:  samp = running && tick;
         CLK_STROBE: samp = running && req_rise;
         CLK_HSHAKE: samp = running && req_lvl && !ack_q;
         default:    samp = 1'b0;
      endcase
   end

   // handshake acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ack_q <= 1'b0;
      else if (!running || mode_q != CLK_HSHAKE)  ack_q <= 1'b0;
      else if (!ack_q && req_lvl)                 ack_q <= 1'b1;
      else if (ack_q && !req_lvl)                 ack_q <= 1'b0;
   end

   assign ack_pin = ack_q ^ pol_q[POL_ACK];

   pic_packer #(.DATA_W(DATA_W)) u_packer (
      .clk   (clk), .rst_n (rst_n),
      .flush (ctrl_wr || !en_q),
      .samp  (samp),
      .wid   (wid_q),
      .full  (fifo_full),
      .din   (din),
      .push  (fifo_wr),
      .drop  (drop),
      .wdata (fifo_wdata)
   );

   assign fifo_clr = clr_q;
   assign overrun  = ovr_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [1:0] cfg_addr,
   input logic       w1c_bit,
   input logic       fifo_full,
   input logic       fifo_wr,
   input logic       fifo_clr,
   input logic       overrun,
   input logic       en_q,
   input logic       ack_q,
   input logic       req_lvl,
   input logic       samp,
   input logic [1:0] mode_q
);
   logic ovr_clr_wr;
   assign ovr_clr_wr = cfg_we && (cfg_addr == 2'd0) && w1c_bit;

   a_r9_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |=> !fifo_wr);

   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !ovr_clr_wr |=> overrun);

   a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !fifo_wr);

   a_r5_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q && req_lvl && !cfg_we |=> ack_q);

   a_r5_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q && (mode_q == 2'd2) |-> !samp);

   a_r8_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr && !cfg_we |=> !fifo_clr);
endmodule

bind pinput_capture pic_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .w1c_bit   (cfg_wdata[7]),
   .fifo_full (fifo_full),
   .fifo_wr   (fifo_wr),
   .fifo_clr  (fifo_clr),
   .overrun   (overrun),
   .en_q      (en_q),
   .ack_q     (ack_q),
   .req_lvl   (req_lvl),
   .samp      (samp),
   .mode_q    (mode_q)
);

// File: tb/pinput_capture_bench.sv
module pinput_capture_bench;
   localparam logic [15:0] EN   = 16'h0001;
   localparam logic [15:0] CLR  = 16'h0002;
   localparam logic [15:0] STRB = 16'h0004;
   localparam logic [15:0] HSK  = 16'h0008;
   localparam logic [15:0] WAIT = 16'h0040;
   localparam logic [15:0] OVRC = 16'h0080;

   logic        clk = 1'b0;
   logic        rst_n, cfg_we, req_pin, trig_pin, fifo_full;
   logic [1:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic [31:0] din;
   logic        ack_pin, fifo_wr, fifo_clr, overrun;
   logic [31:0] fifo_wdata;

   int nvec = 0, nbad = 0, cyc = 0;
   bit done = 0;
   bit req_inv = 0, ack_inv = 0;
   int c0;

   logic [31:0] got_w[$];
   logic [31:0] got_d[$];
   int          got_c[$];
   logic [31:0] smp[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pinput_capture u_pinput_capture (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .din(din), .req_pin(req_pin), .trig_pin(trig_pin),
      .ack_pin(ack_pin), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
      .fifo_wdata(fifo_wdata), .fifo_clr(fifo_clr), .overrun(overrun)
   );

   always @(posedge clk) begin
      #1;
      if (fifo_wr === 1'b1) begin
         got_w.push_back(fifo_wdata);
         got_d.push_back(din);
         got_c.push_back(cyc);
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      finish_up();
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic clear_q();
      got_w.delete(); got_d.delete(); got_c.delete(); smp.delete();
   endtask

   function automatic int lanes(input int wc);
      return (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] pack(input int wc, input logic [31:0] s0, s1, s2, s3);
      case (wc)
         1:       return {s1[15:0], s0[15:0]};
         2:       return {s3[7:0], s2[7:0], s1[7:0], s0[7:0]};
         default: return s0;
      endcase
   endfunction

   function automatic logic [31:0] pacer_exp(input int wc, input logic [31:0] d, input int p);
      logic [31:0] pp;
      pp = p;
      case (wc)
         1:       return pack(1, d - pp, d, 0, 0);
         2:       return pack(2, d - 3*pp, d - 2*pp, d - pp, d);
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] sget(input int i);
      return (i < smp.size()) ? smp[i] : 32'h0;
   endfunction

   task automatic check_smp(input int wc, input string tag);
      int l, n;
      l = lanes(wc);
      n = smp.size() / l;
      chk(got_w.size() == n, {tag, " word count"}, got_w.size(), n);
      for (int i = 0; i < n && i < got_w.size(); i++)
         chk(got_w[i] == pack(wc, sget(i*l), sget(i*l+1), sget(i*l+2), sget(i*l+3)),
             {tag, " packed data"}, got_w[i],
             pack(wc, sget(i*l), sget(i*l+1), sget(i*l+2), sget(i*l+3)));
   endtask

   task automatic strobe(input logic [31:0] v, input bit expect_cap);
      @(negedge clk);
      din = v; req_pin = ~req_inv; c0 = cyc;
      if (expect_cap) smp.push_back(v);
      repeat (4) @(negedge clk);
      req_pin = req_inv;
      repeat (4) @(negedge clk);
   endtask

   task automatic hs_xfer(input logic [31:0] v, input int hold);
      int n;
      @(negedge clk);
      din = v; req_pin = ~req_inv;
      n = 0;
      do begin @(negedge clk); n++; end while ((ack_pin ^ ack_inv) !== 1'b1 && n < 20);
      chk(n == 3, "R5 ack rise latency", n, 3);
      repeat (hold) @(negedge clk);
      chk((ack_pin ^ ack_inv) === 1'b1, "R5 ack held with request", ack_pin, ~ack_inv);
      req_pin = req_inv;
      n = 0;
      do begin @(negedge clk); n++; end while ((ack_pin ^ ack_inv) !== 1'b0 && n < 20);
      chk(n == 3, "R5 ack fall latency", n, 3);
      smp.push_back(v);
   endtask

   task automatic run_pacer(input int wc, input int p);
      int cstop, k, l;
      l = lanes(wc);
      cfg_write(2'd1, 16'h0);
      cfg_write(2'd2, 16'(p - 1));
      clear_q();
      cfg_write(2'd0, EN | 16'(wc << 4));
      repeat (24 * l * p) begin @(negedge clk); din = din + 1; end
      cstop = cyc;
      cfg_write(2'd0, 16'h0);
      repeat (4) @(negedge clk);
      k = 0;
      for (int i = 0; i < got_w.size(); i++) begin
         if (got_c[i] <= cstop) begin
            k++;
            chk(got_w[i] == pacer_exp(wc, got_d[i], p),
                (wc == 0) ? "R2 pacer data" : "R3 packed pacer data",
                got_w[i], pacer_exp(wc, got_d[i], p));
            if (i > 0)
               chk(got_c[i] - got_c[i-1] == l * p, "R2 pacer spacing",
                   got_c[i] - got_c[i-1], l * p);
         end
      end
      chk(k >= 20, "R2 pacer word count", k, 20);
   endtask

   initial begin
      int ct;
      rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; din = 0;
      req_pin = 0; trig_pin = 0; fifo_full = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fifo_wr === 1'b0 && ack_pin === 1'b0, "R1 reset outputs", {fifo_wr, ack_pin}, 0);
      chk(overrun === 1'b0 && fifo_clr === 1'b0, "R1 reset flags", {overrun, fifo_clr}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      chk(fifo_wr === 1'b0 && overrun === 1'b0 && fifo_clr === 1'b0 && ack_pin === 1'b0,
          "R1 idle after reset", {fifo_wr, overrun, fifo_clr, ack_pin}, 0);

      // R2 / R3 pacer, all widths
      for (int wc = 0; wc < 3; wc++) run_pacer(wc, 2 + ($urandom % 5));

      // R4 strobe latency and rising-edge capture
      clear_q();
      cfg_write(2'd0, EN | STRB);
      repeat (3) @(negedge clk);
      strobe($urandom, 1);
      chk(got_c.size() == 1, "R4 strobe single word", got_c.size(), 1);
      if (got_c.size() > 0) chk(got_c[0] - c0 == 3, "R4 strobe latency", got_c[0] - c0, 3);
      check_smp(0, "R4 strobe 32-bit");

      clear_q();
      cfg_write(2'd0, EN | STRB | 16'h0010);
      for (int i = 0; i < 6; i++) strobe($urandom, 1);
      check_smp(1, "R3 strobe 16-bit");

      // R4 inverted request: falling pin edge is active
      cfg_write(2'd0, 16'h0);
      req_inv = 1; req_pin = 1;
      cfg_write(2'd1, 16'h0001);
      repeat (5) @(negedge clk);
      clear_q();
      cfg_write(2'd0, EN | STRB | 16'h0020);
      for (int i = 0; i < 8; i++) strobe($urandom, 1);
      check_smp(2, "R4 inverted strobe 8-bit");
      cfg_write(2'd0, 16'h0);
      req_inv = 0; req_pin = 0;

      // R5 handshake with inverted acknowledge
      cfg_write(2'd1, 16'h0002);
      ack_inv = 1;
      @(negedge clk);
      chk(ack_pin === 1'b1, "R5 inverted ack idle level", ack_pin, 1);
      repeat (4) @(negedge clk);
      clear_q();
      cfg_write(2'd0, EN | HSK);
      for (int i = 0; i < 4; i++) hs_xfer($urandom, 1 + ($urandom % 6));
      check_smp(0, "R5 handshake words");
      cfg_write(2'd0, 16'h0);
      ack_inv = 0;

      // R6 wait for active-low trigger, pacer DIV=2
      trig_pin = 1;
      cfg_write(2'd1, 16'h0004);
      cfg_write(2'd2, 16'd2);
      repeat (4) @(negedge clk);
      clear_q();
      cfg_write(2'd0, EN | WAIT);
      repeat (30) begin @(negedge clk); din = din + 1; end
      chk(got_w.size() == 0, "R6 no capture before trigger", got_w.size(), 0);
      ct = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         din = din + 1;
         if (i == 0) begin trig_pin = 0; ct = cyc; end
         if (i == 3) trig_pin = 1;
      end
      chk(got_w.size() > 5, "R6 capture after trigger", got_w.size(), 6);
      if (got_c.size() > 0) chk(got_c[0] - ct == 6, "R6 first word timing", got_c[0] - ct, 6);
      for (int i = 0; i < got_w.size(); i++)
         chk(got_w[i] == got_d[i], "R6 triggered data", got_w[i], got_d[i]);
      cfg_write(2'd0, 16'h0);
      cfg_write(2'd1, 16'h0);
      trig_pin = 0;

      // R7 disabled: strobes ignored
      repeat (4) @(negedge clk);
      clear_q();
      cfg_write(2'd0, STRB);
      for (int i = 0; i < 3; i++) strobe($urandom, 0);
      chk(got_w.size() == 0, "R7 no write while disabled", got_w.size(), 0);

      // R8 clear pulse discards half-packed word
      clear_q();
      cfg_write(2'd0, EN | STRB | 16'h0010);
      strobe(32'hDEAD_BEEF, 0);
      cfg_write(2'd0, EN | STRB | 16'h0010 | CLR);
      chk(fifo_clr === 1'b1, "R8 clear pulse", fifo_clr, 1);
      @(negedge clk);
      chk(fifo_clr === 1'b0, "R8 clear single cycle", fifo_clr, 0);
      strobe(32'h0000_1111, 1);
      strobe(32'h0000_2222, 1);
      check_smp(1, "R8 partial discarded");

      // R9 / R10 overrun
      clear_q();
      cfg_write(2'd0, EN | STRB);
      fifo_full = 1;
      strobe($urandom, 0);
      chk(got_w.size() == 0, "R9 word dropped when full", got_w.size(), 0);
      chk(overrun === 1'b1, "R9 overrun set", overrun, 1);
      fifo_full = 0;
      cfg_write(2'd0, EN | STRB);
      chk(overrun === 1'b1, "R10 zero write keeps overrun", overrun, 1);
      strobe($urandom, 1);
      check_smp(0, "R9 capture resumes");
      chk(overrun === 1'b1, "R10 overrun sticky", overrun, 1);
      cfg_write(2'd0, EN | STRB | OVRC);
      chk(overrun === 1'b0, "R10 write-one clears", overrun, 0);

      repeat (5) @(negedge clk);
      finish_up();
   end
endmodule